// File: doc/BRIEF.md
# Dual-Port RAM with Inter-Port Lock Flags

A two-port static memory with a left and a right access port. Each port decodes its own controls: a two-wire chip enable, a read/write strobe, an output enable, a lock-flag select, an address and a 9-bit data path. The bidirectional data bus is modelled as an input word, an output word and an output-drive enable. Ordinary accesses read and write one shared array, whose depth is set by a parameter.

When a port is deselected and its lock-flag select is low, the access goes to a separate bank of eight lock flags instead of the array. The two ports share these flags, and arbitration lets only one port own a flag at a time. A port asks for a flag by writing 0 on data bit 0 and gives it up by writing 1. When a port reads a flag it owns, it sees 0 on every data bit. Otherwise it sees 1. A request that cannot be granted stays queued and is granted on its own once the flag comes free. If a port asserts the flag select while it is selected, the access is ignored and the port's error output is raised.

Every access is captured on the rising clock edge. Read data and the output-drive enable appear on the cycle after the access.

Top module: `dps_ram_top`

## Requirements
- R1: A port is selected only when `cs_n` is 0 and `cs` is 1. With `sem_n` high, the other three enable combinations perform no array write and leave `dout_en` low.
- R2: When a port is selected with `rnw`=0 and `sem_n`=1, it writes `din` into the array word at `addr`.
- R3: When a port is selected with `rnw`=1, `oe_n`=0 and `sem_n`=1, the next cycle shows that word on `dout` with `dout_en` high.
- R4: `oe_n` high in a cycle always gives `dout_en` low on the next cycle, whatever the other inputs are.
- R5: A port makes a flag access when it is deselected and `sem_n` is 0. `rnw`=1 with `oe_n`=0 reads a flag and `rnw`=0 writes one. `addr[2:0]` picks one of the eight flags.
- R6: If `sem_n` is 0 while the port is selected, nothing is written to the array or to the flags. On the next cycle `err` is 1 and `dout_en` is 0. In all other cycles `err` is 0.
- R7: A flag write uses only `din[0]`. A flag read puts the flag value on all 9 bits of `dout`.
- R8: Writing `din[0]`=0 requests a flag. The request is granted at that edge unless the other port owns the flag. The owning port then reads 9'h000, and the other port reads 9'h1FF. Writing 1 releases the flag and cancels any queued request from that port.
- R9: If both ports request the same free flag at the same edge, the left port is granted.
- R10: A refused request stays queued. It is granted at the edge where the other port releases the flag.
- R11: If both ports write the same array address at the same edge, the left port's data is stored.
- R12: If one port reads an address at the same edge that the other port writes it, the read returns the data stored before that write.
- R13: After reset every flag is free and reads 9'h1FF from both ports, and `dout_en` and `err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all accesses are taken on its rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_cs_n | input | 1 | Left chip enable, active low half |
| l_cs | input | 1 | Left chip enable, active high half |
| l_rnw | input | 1 | Left read (1) / write (0) |
| l_oe_n | input | 1 | Left output enable, active low |
| l_sem_n | input | 1 | Left lock-flag select, active low |
| l_addr | input | AW | Left address |
| l_din | input | 9 | Left write data |
| l_dout | output | 9 | Left read data |
| l_dout_en | output | 1 | Left data bus drive enable (low = high impedance) |
| l_err | output | 1 | Left illegal-access flag |
| r_cs_n | input | 1 | Right chip enable, active low half |
| r_cs | input | 1 | Right chip enable, active high half |
| r_rnw | input | 1 | Right read (1) / write (0) |
| r_oe_n | input | 1 | Right output enable, active low |
| r_sem_n | input | 1 | Right lock-flag select, active low |
| r_addr | input | AW | Right address |
| r_din | input | 9 | Right write data |
| r_dout | output | 9 | Right read data |
| r_dout_en | output | 1 | Right data bus drive enable |
| r_err | output | 1 | Right illegal-access flag |

## Verification
Writes and flag grants take effect at the edge where the access is presented, so they can be seen by any access made on a later cycle. Read data, `dout_en` and `err` are all due exactly one edge after their access. The bench drives each access on a falling edge and checks the results on the next falling edge, which falls midway between that rising edge and the following one. Every flag ownership change is therefore confirmed with a read in a separate cycle, and a read is never checked in the same cycle as the write or request it depends on.

// File: rtl/dps_pkg.sv
package dps_pkg;

  typedef enum logic [1:0] {
    OWN_FREE = 2'd0,
    OWN_L    = 2'd1,
    OWN_R    = 2'd2
  } own_t;

  typedef struct packed {
    logic mem_wr;
    logic mem_rd;
    logic sem_wr;
    logic sem_rd;
    logic illegal;
  } cmd_t;

  function automatic logic port_selected(input logic cs_n, input logic cs);
    return (!cs_n) && cs;
  endfunction

  function automatic cmd_t decode(input logic cs_n, input logic cs, input logic rnw,
                                  input logic oe_n, input logic sem_n);
    cmd_t c;
    logic sel;
    sel       = port_selected(cs_n, cs);
    c.mem_wr  = sel && sem_n && !rnw;
    c.mem_rd  = sel && sem_n && rnw && !oe_n;
    c.sem_wr  = !sel && !sem_n && !rnw;
    c.sem_rd  = !sel && !sem_n && rnw && !oe_n;
    c.illegal = sel && !sem_n;
    return c;
  endfunction

  // Value a port reads from a flag: 0 when it owns it, 1 otherwise.
  function automatic logic flag_view(input own_t own, input own_t me);
    return (own == me) ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/dps_port_decode.sv
module dps_port_decode
  import dps_pkg::*;
(
  input  logic cs_n,
  input  logic cs,
  input  logic rnw,
  input  logic oe_n,
  input  logic sem_n,
  output cmd_t cmd
);
  always_comb cmd = decode(cs_n, cs, rnw, oe_n, sem_n);
endmodule

// File: rtl/dps_mem_array.sv
module dps_mem_array #(
  parameter int AW = 6,
  parameter int DW = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           we,
  input  logic [1:0][AW-1:0]   addr,
  input  logic [1:0][DW-1:0]   wdata,
  output logic [1:0][DW-1:0]   rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  // Right first, left last: the left port wins on a shared address.
  always_ff @(posedge clk) begin
    if (we[1]) mem[addr[1]] <= wdata[1];
    if (we[0]) mem[addr[0]] <= wdata[0];
  end

  // Combinational read of the pre-edge contents; registered by the top.
  always_comb begin
    rdata[0] = mem[addr[0]];
    rdata[1] = mem[addr[1]];
  end

  wire same_addr_wr = we[0] && we[1] && (addr[0] == addr[1]);

  assert_left_wins_R11: assert property (@(posedge clk) disable iff (!rst_n)
    same_addr_wr |=> (mem[$past(addr[0])] == $past(wdata[0])));

endmodule

// File: rtl/dps_sema_bank.sv
module dps_sema_bank
  import dps_pkg::*;
#(
  parameter int NF = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [1:0]            wr,
  input  logic [1:0][$clog2(NF)-1:0] idx,
  input  logic [1:0]            wbit,
  output logic [1:0]            flag
);
  localparam int FW = $clog2(NF);

  own_t        own_q  [NF];
  logic [NF-1:0] lwant_q, rwant_q;
  logic [NF-1:0] lreq, rreq, lrel, rrel;

  generate
    for (genvar i = 0; i < NF; i++) begin : g_flag
      logic lw_n, rw_n;
      own_t held;

      always_comb begin
        lreq[i] = wr[0] && (idx[0] == FW'(i)) && !wbit[0];
        lrel[i] = wr[0] && (idx[0] == FW'(i)) &&  wbit[0];
        rreq[i] = wr[1] && (idx[1] == FW'(i)) && !wbit[1];
        rrel[i] = wr[1] && (idx[1] == FW'(i)) &&  wbit[1];
        lw_n = (lwant_q[i] || lreq[i]) && !lrel[i];
        rw_n = (rwant_q[i] || rreq[i]) && !rrel[i];
        held = own_q[i];
        if (held == OWN_L && !lw_n) held = OWN_FREE;
        if (held == OWN_R && !rw_n) held = OWN_FREE;
        if (held == OWN_FREE) held = lw_n ? OWN_L : (rw_n ? OWN_R : OWN_FREE);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          own_q[i]   <= OWN_FREE;
          lwant_q[i] <= 1'b0;
          rwant_q[i] <= 1'b0;
        end else begin
          own_q[i]   <= held;
          lwant_q[i] <= lw_n;
          rwant_q[i] <= rw_n;
        end
      end

      assert_left_priority_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q[i] == OWN_FREE && lreq[i] && rreq[i]) |=> (own_q[i] == OWN_L));

      assert_no_steal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q[i] == OWN_R && !rrel[i]) |=> (own_q[i] == OWN_R));

      assert_queued_grant_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (own_q[i] == OWN_L && lrel[i] && rwant_q[i] && !rrel[i]) |=> (own_q[i] == OWN_R));
    end
  endgenerate

  always_comb begin
    flag[0] = flag_view(own_q[idx[0]], OWN_L);
    flag[1] = flag_view(own_q[idx[1]], OWN_R);
  end

endmodule

// File: rtl/dps_ram_top.sv
module dps_ram_top
  import dps_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 9,
  parameter int NF = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          l_cs_n,
  input  logic          l_cs,
  input  logic          l_rnw,
  input  logic          l_oe_n,
  input  logic          l_sem_n,
  input  logic [AW-1:0] l_addr,
  input  logic [DW-1:0] l_din,
  output logic [DW-1:0] l_dout,
  output logic          l_dout_en,
  output logic          l_err,
  input  logic          r_cs_n,
  input  logic          r_cs,
  input  logic          r_rnw,
  input  logic          r_oe_n,
  input  logic          r_sem_n,
  input  logic [AW-1:0] r_addr,
  input  logic [DW-1:0] r_din,
  output logic [DW-1:0] r_dout,
  output logic          r_dout_en,
  output logic          r_err
);
  localparam int FW = $clog2(NF);

  logic [1:0]          cs_n_a, cs_a, rnw_a, oe_n_a, sem_n_a;
  logic [1:0][AW-1:0]  addr_a;
  logic [1:0][DW-1:0]  din_a, rdata_a, dout_q;
  logic [1:0]          doe_q, err_q, we_a, swr_a, wbit_a, flag_a;
  logic [1:0][FW-1:0]  fidx_a;
  cmd_t                cmd_a [2];

  assign cs_n_a  = {r_cs_n,  l_cs_n};
  assign cs_a    = {r_cs,    l_cs};
  assign rnw_a   = {r_rnw,   l_rnw};
  assign oe_n_a  = {r_oe_n,  l_oe_n};
  assign sem_n_a = {r_sem_n, l_sem_n};
  assign addr_a  = {r_addr,  l_addr};
  assign din_a   = {r_din,   l_din};

  generate
    for (genvar p = 0; p < 2; p++) begin : g_port
      dps_port_decode u_dec (
        .cs_n (cs_n_a[p]), .cs (cs_a[p]), .rnw (rnw_a[p]),
        .oe_n (oe_n_a[p]), .sem_n (sem_n_a[p]), .cmd (cmd_a[p])
      );

      assign we_a[p]   = cmd_a[p].mem_wr;
      assign swr_a[p]  = cmd_a[p].sem_wr;
      assign wbit_a[p] = din_a[p][0];
      assign fidx_a[p] = addr_a[p][FW-1:0];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          dout_q[p] <= '0;
          doe_q[p]  <= 1'b0;
          err_q[p]  <= 1'b0;
        end else begin
          doe_q[p] <= cmd_a[p].mem_rd || cmd_a[p].sem_rd;
          err_q[p] <= cmd_a[p].illegal;
          if (cmd_a[p].mem_rd)      dout_q[p] <= rdata_a[p];
          else if (cmd_a[p].sem_rd) dout_q[p] <= {DW{flag_a[p]}};
          else                      dout_q[p] <= '0;
        end
      end

      assert_oe_hiz_R4: assert property (@(posedge clk) disable iff (!rst_n)
        oe_n_a[p] |=> !doe_q[p]);

      assert_illegal_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n_a[p] && cs_a[p] && !sem_n_a[p]) |=> (err_q[p] && !doe_q[p]));
    end
  endgenerate

  dps_mem_array #(.AW(AW), .DW(DW)) u_mem (
    .clk (clk), .rst_n (rst_n), .we (we_a), .addr (addr_a),
    .wdata (din_a), .rdata (rdata_a)
  );

  dps_sema_bank #(.NF(NF)) u_sema (
    .clk (clk), .rst_n (rst_n), .wr (swr_a), .idx (fidx_a),
    .wbit (wbit_a), .flag (flag_a)
  );

  assign l_dout    = dout_q[0];
  assign r_dout    = dout_q[1];
  assign l_dout_en = doe_q[0];
  assign r_dout_en = doe_q[1];
  assign l_err     = err_q[0];
  assign r_err     = err_q[1];

endmodule

// File: tb/tb_dps_ram_top.sv
`timescale 1ns/1ps
module tb_dps_ram_top;
  localparam int AW = 6;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0;
  logic l_cs_n, l_cs, l_rnw, l_oe_n, l_sem_n, r_cs_n, r_cs, r_rnw, r_oe_n, r_sem_n;
  logic [AW-1:0] l_addr, r_addr;
  logic [8:0] l_din, r_din, l_dout, r_dout;
  logic l_dout_en, r_dout_en, l_err, r_err;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  dps_ram_top #(.AW(AW)) dut (.*);

  function automatic logic [8:0] pat_l(input int a); return 9'((a * 37 + 5) % 512); endfunction
  function automatic logic [8:0] pat_r(input int a); return 9'((a * 101 + 300) % 512); endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic lset(input logic csn, input logic cs, input logic rnw, input logic oen,
                      input logic semn, input int a, input logic [8:0] d);
    l_cs_n = csn; l_cs = cs; l_rnw = rnw; l_oe_n = oen; l_sem_n = semn;
    l_addr = AW'(a); l_din = d;
  endtask
  task automatic rset(input logic csn, input logic cs, input logic rnw, input logic oen,
                      input logic semn, input int a, input logic [8:0] d);
    r_cs_n = csn; r_cs = cs; r_rnw = rnw; r_oe_n = oen; r_sem_n = semn;
    r_addr = AW'(a); r_din = d;
  endtask
  task automatic idle(); lset(1,0,1,1,1,0,0); rset(1,0,1,1,1,0,0); endtask
  task automatic step(); @(negedge clk); endtask

  // Flag reads from both ports, result checked one edge later.
  task automatic sem_both(input int f, input logic [8:0] el, input logic [8:0] er, input string tag);
    lset(1,0,1,0,0,f,0); rset(1,0,1,0,0,f,0); step();
    chk({tag, " L flag"}, {l_dout_en, l_dout}, {1'b1, el});
    chk({tag, " R flag"}, {r_dout_en, r_dout}, {1'b1, er});
    idle();
  endtask

  initial begin
    #(20 * 20000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    idle();
    step(); step();
    // R13: reset state
    chk("R13 l_dout_en", l_dout_en, 0); chk("R13 r_err", r_err, 0);
    rst_n = 1; step();
    for (int f = 0; f < 8; f++) sem_both(f, 9'h1FF, 9'h1FF, "R13 reset free");

    // R2/R3: left fills, right reads back
    for (int a = 0; a < DEPTH; a++) begin lset(0,1,0,1,1,a,pat_l(a)); step(); end
    idle();
    for (int a = 0; a < DEPTH; a++) begin
      rset(0,1,1,0,1,a,0); step();
      chk("R3 right read", {r_dout_en, r_dout}, {1'b1, pat_l(a)});
    end
    // R2/R3: right fills, left reads back
    for (int a = 0; a < DEPTH; a++) begin rset(0,1,0,1,1,a,pat_r(a)); lset(1,0,1,1,1,0,0); step(); end
    idle();
    for (int a = 0; a < DEPTH; a++) begin
      lset(0,1,1,0,1,a,0); rset(1,0,1,1,1,0,0); step();
      chk("R2 left read", {l_dout_en, l_dout}, {1'b1, pat_r(a)});
    end
    idle();

    // R1: deselect combos write nothing and drive nothing
    for (int c = 0; c < 4; c++) begin
      if (c == 1) continue;
      lset(c[1], c[0], 0, 1, 1, 10 + c, 9'h0AA); step();
      lset(c[1], c[0], 1, 0, 1, 10 + c, 0); step();
      chk("R1 deselected no drive", l_dout_en, 0);
      lset(0,1,1,0,1,10 + c,0); step();
      chk("R1 deselected no write", l_dout, pat_r(10 + c));
    end
    idle();

    // R4: output enable high blocks the bus
    lset(0,1,1,1,1,3,0); rset(1,0,1,1,0,3,0); step();
    chk("R4 mem oe_n high", l_dout_en, 0); chk("R4 flag oe_n high", r_dout_en, 0);
    idle();

    // R6: selected with flag select low is ignored and flagged
    lset(0,1,0,1,0,2,9'h000); step();
    chk("R6 err raised", {l_err, l_dout_en}, 2'b10);
    idle(); step();
    chk("R6 err one cycle", l_err, 0);
    lset(0,1,1,0,1,2,0); step();
    chk("R6 array untouched", l_dout, pat_r(2));
    idle();
    sem_both(2, 9'h1FF, 9'h1FF, "R6 flag untouched");

    // R11: both ports write the same word
    lset(0,1,0,1,1,5,9'h123); rset(0,1,0,1,1,5,9'h0F0); step();
    lset(0,1,1,0,1,5,0); rset(1,0,1,1,1,0,0); step();
    chk("R11 left wins", l_dout, 9'h123);
    // R12: read during write returns old data
    lset(0,1,0,1,1,7,9'h155); rset(0,1,1,0,1,7,0); step();
    chk("R12 old data", r_dout, pat_r(7));
    idle();
    rset(0,1,1,0,1,7,0); step();
    chk("R12 new data later", r_dout, 9'h155);
    idle();

    // R5/R7/R8/R10/R9 per flag
    for (int f = 0; f < 8; f++) begin
      lset(1,0,0,1,0,f,9'h1FE); step(); idle();          // R7: only bit 0 counts
      sem_both(f, 9'h000, 9'h1FF, "R8 left owns");
      for (int o = 0; o < 8; o++) if (o != f)
        if (o == (f + 1) % 8) sem_both(o, 9'h1FF, 9'h1FF, "R5 other flag free");
      rset(1,0,0,1,0,f,9'h000); step(); idle();
      sem_both(f, 9'h000, 9'h1FF, "R8 refused");
      lset(1,0,0,1,0,f,9'h001); step(); idle();          // release, right queued
      sem_both(f, 9'h1FF, 9'h000, "R10 queued grant");
      rset(1,0,0,1,0,f,9'h1FF); step(); idle();
      sem_both(f, 9'h1FF, 9'h1FF, "R8 released");
      lset(1,0,0,1,0,f,9'h000); rset(1,0,0,1,0,f,9'h000); step(); idle();
      sem_both(f, 9'h000, 9'h1FF, "R9 left priority");
      lset(1,0,0,1,0,f,9'h001); rset(1,0,0,1,0,f,9'h001); step(); idle();
      sem_both(f, 9'h1FF, 9'h1FF, "R8 both released");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule